// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns a single start-stop serial line into bytes held in a receive queue. It follows an external oversampling strobe, `tick`. That strobe pulses `OVS` times per bit period, and a separate rate generator produces it. The frame layout is chosen at run time. A character can carry 7 or 8 data bits, one or two stop bits, and no parity, even parity or odd parity. The receiver captures the format when it accepts a start bit, so a change to the configuration takes effect from the next character.

Each completed character enters a `DEPTH`-entry show-ahead queue together with its own parity-error flag and framing-error flag. A character that finds the queue full is dropped and sets a sticky overrun flag. A framing error followed by the line held low for a whole further frame time sets a sticky break flag. No characters are stored until the line goes high again and a fresh start edge appears. Both sticky flags are cleared by write-one pulses.

The controlling state machine has eight states, in the order a frame is received:

- `ST_IDLE`: waits for a low sample on a tick.
- `ST_START`: confirms the start bit at mid-bit.
- `ST_DATA`: shifts in data bits.
- `ST_PARITY`: takes the parity bit.
- `ST_STOP1`: checks the first stop bit.
- `ST_STOP2`: checks the second stop bit.
- `ST_BRKCHK`: times the low line after a framing error.
- `ST_BRKHOLD`: waits for the line to go high.

The transitions are:

- IDLE to START on a low tick.
- START back to IDLE when the mid sample is high.
- START to DATA when the mid sample is low.
- DATA to PARITY or STOP1 after the last data bit.
- PARITY to STOP1.
- STOP1 to STOP2 in two-stop mode.
- STOP1 or STOP2 to IDLE when the final stop bit is high.
- STOP1 or STOP2 to BRKCHK when the final stop bit is low.
- BRKCHK to IDLE when the line goes high.
- BRKCHK to BRKHOLD once a frame time has passed with the line low.
- BRKHOLD to IDLE when the line goes high.

Top module: `serial_frame_receiver`

## Requirements
- R1: After reset the queue is empty, `rx_level` is 0, `rx_empty` is 1, and `overrun` and `brk` are 0.
- R2: In 8-bit mode the data bits are taken least significant bit first, each at the centre of its bit time. They are presented on `rx_data[7:0]` with `rx_frm_err=0` and `rx_par_err=0` for a clean frame.
- R3: In 7-bit mode the seven received bits occupy `rx_data[6:0]` and `rx_data[7]` is 0.
- R4: When `cfg_par_en=1` one parity bit follows the data. With `cfg_par_odd=0` the data bits plus the parity bit must contain an even number of ones; with `cfg_par_odd=1` an odd number. A mismatch sets `rx_par_err` for that character. When `cfg_par_en=0` no parity bit is expected and `rx_par_err` is 0.
- R5: `cfg_stop2=1` selects two stop bits and `cfg_stop2=0` selects one. A low sample at any checked stop bit sets `rx_frm_err` for that character.
- R6: Characters leave the queue in arrival order. `rx_level` counts the stored entries, up to `DEPTH` (16). A pulse on `rx_pop` while not empty removes the head entry; a pulse while empty changes nothing.
- R7: A character that completes while `DEPTH` entries are held is discarded, the stored entries are unchanged, and `overrun` goes to 1.
- R8: `overrun` and `brk` stay at 1 until a one-cycle pulse on `clr_overrun` or `clr_break` respectively returns them to 0.
- R9: A low pulse shorter than half a bit time that is high again at the start-bit mid sample (the `OVS/2`-th tick after detection) is ignored and stores nothing.
- R10: After a character with a low final stop bit, `brk` goes to 1 once the line has stayed low for one full frame time of that format. No character is stored during the break. Reception resumes only after the line returns high and a new start edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| tick | input | 1 | Oversampling strobe, OVS pulses per bit |
| cfg_len7 | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| cfg_stop2 | input | 1 | 1 = two stop bits, 0 = one |
| cfg_par_en | input | 1 | 1 = a parity bit is present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_pop | input | 1 | Removes the head entry of the queue |
| rx_data | output | 8 | Data of the head entry |
| rx_par_err | output | 1 | Parity-error flag of the head entry |
| rx_frm_err | output | 1 | Framing-error flag of the head entry |
| rx_empty | output | 1 | Queue holds no entry |
| rx_level | output | $clog2(DEPTH+1) | Number of stored entries |
| overrun | output | 1 | Sticky overrun flag |
| brk | output | 1 | Sticky break flag |
| clr_overrun | input | 1 | Write-one clear of `overrun` |
| clr_break | input | 1 | Write-one clear of `brk` |

## Verification
The bench builds the receiver with `OVS=16` and `DEPTH=16`, and gives it a strobe on every second clock, so each bit lasts 32 clocks. These values keep a full-queue overrun (17 frames) and a full-frame break hold short enough to run alongside a sweep of all twelve combinations of data length, stop count and parity mode. That sweep uses five data patterns, and every frame is also sent with a corrupted parity bit and with corrupted stop bits. Expected bytes and flags are derived arithmetically from the transmitted bit pattern.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2,
        ST_BRKCHK,
        ST_BRKHOLD
    } srx_state_t;

    typedef struct packed {
        logic       frm_err;
        logic       par_err;
        logic [7:0] data;
    } srx_word_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rxd_s,
    input  logic      tick,
    input  logic      cfg_len7,
    input  logic      cfg_stop2,
    input  logic      cfg_par_en,
    input  logic      cfg_par_odd,
    input  logic      clr_break,
    output logic      push,
    output srx_word_t push_word,
    output logic      brk
);
    localparam int CW      = $clog2(OVS);
    localparam int HALF    = OVS / 2;
    localparam int BRK_MAX = 12 * OVS;
    localparam int BW      = $clog2(BRK_MAX + 1);

    srx_state_t     state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic [2:0]     bit_q;
    logic [7:0]     shreg_q;
    logic           len7_q, stop2_q, pen_q, podd_q;
    logic           perr_q, ferr_q, brk_q;
    logic [BW-1:0]  brk_cnt_q;
    logic [BW-1:0]  frame_ticks;
    logic           bit_tick, mid_tick, last_data, brk_hit;
    logic [7:0]     data_val;

    assign bit_tick  = tick && (cnt_q == CW'(OVS - 1));
    assign mid_tick  = tick && (cnt_q == CW'(HALF));
    assign last_data = (bit_q == (len7_q ? 3'd6 : 3'd7));
    assign data_val  = len7_q ? {1'b0, shreg_q[7:1]} : shreg_q;

    always_comb begin
        int nbits;
        nbits = 1 + (len7_q ? 7 : 8) + (pen_q ? 1 : 0) + (stop2_q ? 2 : 1);
        frame_ticks = BW'(nbits * OVS);
    end

    assign brk_hit = (state_q == ST_BRKCHK) && tick && !rxd_s
                     && (brk_cnt_q == frame_ticks - BW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (tick && !rxd_s) state_d = ST_START;
            ST_START:   if (mid_tick) state_d = rxd_s ? ST_IDLE : ST_DATA;
            ST_DATA:    if (bit_tick && last_data) state_d = pen_q ? ST_PARITY : ST_STOP1;
            ST_PARITY:  if (bit_tick) state_d = ST_STOP1;
            ST_STOP1:   if (bit_tick) begin
                            if (stop2_q)     state_d = ST_STOP2;
                            else if (!rxd_s) state_d = ST_BRKCHK;
                            else             state_d = ST_IDLE;
                        end
            ST_STOP2:   if (bit_tick) state_d = rxd_s ? ST_IDLE : ST_BRKCHK;
            ST_BRKCHK:  if (tick) begin
                            if (rxd_s)        state_d = ST_IDLE;
                            else if (brk_hit) state_d = ST_BRKHOLD;
                        end
            ST_BRKHOLD: if (rxd_s) state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            bit_q     <= '0;
            shreg_q   <= '0;
            len7_q    <= 1'b0;
            stop2_q   <= 1'b0;
            pen_q     <= 1'b0;
            podd_q    <= 1'b0;
            perr_q    <= 1'b0;
            ferr_q    <= 1'b0;
            brk_cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (tick && !rxd_s) begin
                        cnt_q   <= CW'(1);
                        len7_q  <= cfg_len7;
                        stop2_q <= cfg_stop2;
                        pen_q   <= cfg_par_en;
                        podd_q  <= cfg_par_odd;
                    end
                end
                ST_START: if (tick) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (mid_tick) begin
                        cnt_q  <= '0;
                        bit_q  <= '0;
                        perr_q <= 1'b0;
                        ferr_q <= 1'b0;
                    end
                end
                ST_DATA: if (tick) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (bit_tick) begin
                        cnt_q   <= '0;
                        shreg_q <= {rxd_s, shreg_q[7:1]};
                        bit_q   <= bit_q + 1'b1;
                    end
                end
                ST_PARITY: if (tick) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (bit_tick) begin
                        cnt_q  <= '0;
                        perr_q <= (^data_val) ^ rxd_s ^ podd_q;
                    end
                end
                ST_STOP1, ST_STOP2: if (tick) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (bit_tick) begin
                        cnt_q     <= '0;
                        ferr_q    <= ferr_q | !rxd_s;
                        brk_cnt_q <= '0;
                    end
                end
                ST_BRKCHK: if (tick) brk_cnt_q <= brk_cnt_q + 1'b1;
                ST_BRKHOLD: cnt_q <= '0;
            endcase
        end
    end

    // sticky break flag, set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         brk_q <= 1'b0;
        else if (brk_hit)   brk_q <= 1'b1;
        else if (clr_break) brk_q <= 1'b0;
    end

    // outputs
    always_comb begin
        push = bit_tick && (((state_q == ST_STOP1) && !stop2_q) || (state_q == ST_STOP2));
        push_word.data    = data_val;
        push_word.par_err = perr_q;
        push_word.frm_err = ferr_q | !rxd_s;
        brk = brk_q;
    end

    // R10
    brk_needs_low_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_q) |-> $past(!rxd_s));

    // R8
    brk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_q && !clr_break) |=> brk_q);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  srx_word_t                  wr_word,
    input  logic                       rd_en,
    output srx_word_t                  rd_word,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    srx_word_t     mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [LW-1:0] cnt_q;
    logic          do_wr, do_rd;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == LW'(DEPTH));
    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) wp_q <= wp_q + 1'b1;
            if (do_rd) rp_q <= rp_q + 1'b1;
            if (do_wr && !do_rd)      cnt_q <= cnt_q + 1'b1;
            else if (do_rd && !do_wr) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem_q[wp_q] <= wr_word;
    end

    assign rd_word = mem_q[rp_q];
    assign level   = cnt_q;

    // R6
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LW'(DEPTH));

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en) |=> (cnt_q == '0));
endmodule

// File: rtl/serial_frame_receiver.sv
module serial_frame_receiver
    import srx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rxd,
    input  logic                       tick,
    input  logic                       cfg_len7,
    input  logic                       cfg_stop2,
    input  logic                       cfg_par_en,
    input  logic                       cfg_par_odd,
    input  logic                       rx_pop,
    output logic [7:0]                 rx_data,
    output logic                       rx_par_err,
    output logic                       rx_frm_err,
    output logic                       rx_empty,
    output logic [$clog2(DEPTH+1)-1:0] rx_level,
    output logic                       overrun,
    output logic                       brk,
    input  logic                       clr_overrun,
    input  logic                       clr_break
);
    logic      rxd_s, push, q_full, ovr_q;
    srx_word_t push_word, head_word;

    srx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
    );

    srx_frame_fsm #(.OVS(OVS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rxd_s(rxd_s), .tick(tick),
        .cfg_len7(cfg_len7), .cfg_stop2(cfg_stop2),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .clr_break(clr_break), .push(push), .push_word(push_word), .brk(brk)
    );

    srx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(push && !q_full), .wr_word(push_word),
        .rd_en(rx_pop), .rd_word(head_word), .empty(rx_empty),
        .full(q_full), .level(rx_level)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              ovr_q <= 1'b0;
        else if (push && q_full) ovr_q <= 1'b1;
        else if (clr_overrun)    ovr_q <= 1'b0;
    end

    assign overrun    = ovr_q;
    assign rx_data    = head_word.data;
    assign rx_par_err = head_word.par_err;
    assign rx_frm_err = head_word.frm_err;

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !clr_overrun) |=> ovr_q);

    // R7
    drop_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && q_full && !rx_pop) |=> (rx_level == $past(rx_level)));
endmodule

// File: tb/tb_serial_frame_receiver.sv
`timescale 1ns/1ps
module tb_serial_frame_receiver;
    localparam int OVS   = 16;
    localparam int DEPTH = 16;
    localparam int BITC  = 2 * OVS;   // strobe every other clock

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       tick = 1'b0;
    logic       cfg_len7 = 1'b0, cfg_stop2 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       rx_pop = 1'b0, clr_overrun = 1'b0, clr_break = 1'b0;
    logic [7:0] rx_data;
    logic       rx_par_err, rx_frm_err, rx_empty, overrun, brk;
    logic [$clog2(DEPTH+1)-1:0] rx_level;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    serial_frame_receiver #(.OVS(OVS), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick),
        .cfg_len7(cfg_len7), .cfg_stop2(cfg_stop2),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_empty(rx_empty), .rx_level(rx_level),
        .overrun(overrun), .brk(brk),
        .clr_overrun(clr_overrun), .clr_break(clr_break)
    );

    initial begin
        forever begin
            @(negedge clk);
            tick = ~tick;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_bits(input logic lvl, input int nbits);
        rxd = lvl;
        repeat (nbits * BITC) @(negedge clk);
    endtask

    // bad_par flips the parity bit; bad_stop: bit0 = first stop low, bit1 = second stop low
    task automatic send(input logic [7:0] d, input bit bad_par, input bit [1:0] bad_stop);
        int  nd;
        bit  p;
        nd = cfg_len7 ? 7 : 8;
        hold_bits(1'b0, 1);
        for (int i = 0; i < nd; i++) hold_bits(d[i], 1);
        if (cfg_par_en) begin
            p = cfg_len7 ? ^d[6:0] : ^d;
            if (cfg_par_odd) p = ~p;
            hold_bits(p ^ bad_par, 1);
        end
        hold_bits(!bad_stop[0], 1);
        if (cfg_stop2) hold_bits(!bad_stop[1], 1);
        hold_bits(1'b1, 2);
    endtask

    task automatic pop_check(input logic [7:0] d, input bit pe, input bit fe, input string req);
        check(!rx_empty, req, rx_empty, 0);
        check(rx_data == d, req, rx_data, d);
        check(rx_par_err == pe, req, rx_par_err, pe);
        check(rx_frm_err == fe, req, rx_frm_err, fe);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] pats [5];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C; pats[4] = 8'h81;

        repeat (5) @(negedge clk);
        // R1 reset state
        check(rx_empty == 1'b1, "R1", rx_empty, 1);
        check(rx_level == 0, "R1", rx_level, 0);
        check(overrun == 1'b0 && brk == 1'b0, "R1", {overrun, brk}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 R3 R4 R5: sweep of twelve format combinations
        for (int f = 0; f < 12; f++) begin
            cfg_len7    = f[0];
            cfg_stop2   = f[1];
            cfg_par_en  = (f / 4) != 0;
            cfg_par_odd = (f / 4) == 2;
            for (int k = 0; k < 5; k++) begin
                logic [7:0] ex;
                ex = cfg_len7 ? (pats[k] & 8'h7F) : pats[k];
                send(pats[k], 1'b0, 2'b00);
                pop_check(ex, 1'b0, 1'b0, cfg_len7 ? "R3" : "R2");
                if (cfg_par_en) begin
                    send(pats[k], 1'b1, 2'b00);
                    pop_check(ex, 1'b1, 1'b0, "R4");
                end
                send(pats[k], 1'b0, cfg_stop2 ? 2'b10 : 2'b01);
                pop_check(ex, 1'b0, 1'b1, "R5");
                if (cfg_stop2) begin
                    send(pats[k], 1'b0, 2'b01);
                    pop_check(ex, 1'b0, 1'b1, "R5");
                end
            end
        end
        check(brk == 1'b0, "R10", brk, 0);

        // R9 glitch rejection
        cfg_len7 = 1'b0; cfg_stop2 = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
        rxd = 1'b0; repeat (6) @(negedge clk);
        rxd = 1'b1; repeat (2 * BITC) @(negedge clk);
        rxd = 1'b0; repeat (12) @(negedge clk);
        rxd = 1'b1; repeat (2 * BITC) @(negedge clk);
        check(rx_level == 0 && rx_empty, "R9", rx_level, 0);

        // R6 R7 fill to depth, then overrun
        for (int i = 0; i < DEPTH; i++) send(8'(i * 7 + 3), 1'b0, 2'b00);
        check(rx_level == DEPTH, "R6", rx_level, DEPTH);
        check(overrun == 1'b0, "R7", overrun, 0);
        send(8'hEE, 1'b0, 2'b00);
        check(overrun == 1'b1, "R7", overrun, 1);
        check(rx_level == DEPTH, "R7", rx_level, DEPTH);
        for (int i = 0; i < DEPTH; i++) pop_check(8'(i * 7 + 3), 1'b0, 1'b0, "R6");
        check(rx_empty == 1'b1, "R7", rx_empty, 1);
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0; @(negedge clk);
        check(rx_level == 0, "R6", rx_level, 0);
        // R8 overrun held until cleared
        check(overrun == 1'b1, "R8", overrun, 1);
        clr_overrun = 1'b1; @(negedge clk); clr_overrun = 1'b0; @(negedge clk);
        check(overrun == 1'b0, "R8", overrun, 0);

        // R10 break detection (8N1: 10-bit frame)
        hold_bits(1'b0, 10);       // start + data 0 + low stop
        hold_bits(1'b0, 2);
        check(brk == 1'b0, "R10", brk, 0);
        hold_bits(1'b0, 12);
        check(brk == 1'b1, "R10", brk, 1);
        check(rx_level == 1, "R10", rx_level, 1);
        hold_bits(1'b1, 2);
        send(8'h5A, 1'b0, 2'b00);
        check(rx_level == 2, "R10", rx_level, 2);
        pop_check(8'h00, 1'b0, 1'b1, "R10");
        pop_check(8'h5A, 1'b0, 1'b0, "R10");
        check(brk == 1'b1, "R8", brk, 1);
        clr_break = 1'b1; @(negedge clk); clr_break = 1'b0; @(negedge clk);
        check(brk == 1'b0, "R8", brk, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule